// File: doc/BRIEF.md
# Reset Delay Sequencer

This block holds a small processor core in reset after any reset event and lets it go only after a programmable delay has elapsed. It runs entirely on a free-running slow tick clock that is independent of the core clock, so its timing continues while the core clock is stopped during sleep. Three kinds of event start a reset: power-on, a low level on the external clear input, and a watchdog expiry pulse. The watchdog pulse can be switched off by a configuration bit.

The delay length is one of two tick counts, long or short. The choice depends on the oscillator mode and on whether the pending reset is still the first one after power-on. Crystal modes always wait the long delay. The two RC modes wait the long delay only after power-on and the short delay for every later reset. Alongside the reset, the block reports a time-out status flag that tells a watchdog reset apart from the other kinds. It also gives a one-tick wake pulse when the watchdog fires during sleep.

Top module: `rst_delay_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 in the same cycle without waiting for a clock edge. After the first rising edge with `por_i` high, `tmo_flag_o` is 1 and `wake_pulse_o` is 0.
- R2: While `ext_clear_n_i` is low, `core_rst_o` stays 1. The delay D starts only once the clear input is seen high through a two-stage synchronizer. `core_rst_o` falls after the (D+3)-th rising edge counted from the edge after `ext_clear_n_i` rises, and the same timing applies when `por_i` falls with the clear input high.
- R3: In the RC modes (`osc_mode_i` = 2'b10 internal RC, 2'b11 external RC), the first delay after power-on is LONG_TICKS. This holds even if an external clear interrupts that first delay. Every later reset uses SHORT_TICKS.
- R4: In the crystal modes (`osc_mode_i` = 2'b00 low-power crystal, 2'b01 standard crystal), every reset uses LONG_TICKS.
- R5: A rising edge on `wdog_expire_i` (high for at least one tick) is accepted when `wdog_en_i` is 1 and the clear input is high. `core_rst_o` rises after the third rising edge and falls after the (D+3)-th, both counted from the edge after the pulse rises. This holds from run state and while a delay is counting.
- R6: `tmo_flag_o` is set to 1 by power-on and by an external clear. It is cleared to 0 by an accepted watchdog reset, and it keeps its value otherwise.
- R7: With `wdog_en_i` at 0, watchdog pulses have no effect: `core_rst_o`, `tmo_flag_o` and `wake_pulse_o` do not change.
- R8: `wake_pulse_o` is high for exactly one tick, after the same edge that asserts reset for an accepted watchdog pulse, and only if `sleep_i` is 1 at that edge.
- R9: A reset event that arrives while the delay is counting reloads the counter with the delay that fits the new event. Release then happens D+3 edges after that new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tick_clk_i | input | 1 | Free-running slow timer clock |
| por_i | input | 1 | Power-on reset flag, active high, synchronous reset of the block |
| ext_clear_n_i | input | 1 | External clear level, low holds the core in reset |
| wdog_expire_i | input | 1 | Watchdog expiry pulse, asynchronous |
| osc_mode_i | input | 2 | Oscillator mode: 00/01 crystal, 10/11 RC |
| wdog_en_i | input | 1 | Watchdog enable configuration bit |
| sleep_i | input | 1 | Core is in sleep |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| tmo_flag_o | output | 1 | Time-out status flag, 0 after a watchdog reset |
| wake_pulse_o | output | 1 | One-tick pulse on a watchdog wake from sleep |

## Verification
Assertions check a set of rules on every tick. A low synchronized clear holds reset. Reset is never released without the clear high. Each accepted watchdog edge asserts reset, clears the flag and raises the wake pulse only with sleep high, and that pulse never lasts two ticks. With the watchdog disabled, a core in run state stays there. Exact delay lengths depend on the mode and on whether power-on is still pending, so only the bench's timed scenarios can show them. The same holds for the reload of a counter already running and for the long power-on delay surviving an interrupting clear.

// File: rtl/rds_pkg.sv
package rds_pkg;

    typedef enum logic [1:0] {
        OSC_XTAL_LOWPWR = 2'b00,
        OSC_XTAL_STD    = 2'b01,
        OSC_RC_INT      = 2'b10,
        OSC_RC_EXT      = 2'b11
    } osc_mode_e;

    typedef enum logic [1:0] {
        SEQ_WAIT_CLR = 2'b00,
        SEQ_COUNT    = 2'b01,
        SEQ_RUN      = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic clr_low;
        logic wdog_take;
        logic asleep;
    } seq_evt_t;

    function automatic logic is_rc_mode(input osc_mode_e mode);
        return (mode == OSC_RC_INT) || (mode == OSC_RC_EXT);
    endfunction

    function automatic logic wants_long(input logic por_pending, input osc_mode_e mode);
        return por_pending || !is_rc_mode(mode);
    endfunction

endpackage

// File: rtl/rds_sync.sv
module rds_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[g] <= 1'b0;
                else       stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[g] <= 1'b0;
                else       stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rds_delay_counter.sv
module rds_delay_counter #(
    parameter int unsigned LONG_TICKS  = 4608,
    parameter int unsigned SHORT_TICKS = 77
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic use_long_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LAST_V  = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= use_long_i ? LONG_V : SHORT_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAST_V;
        end
    end

    // Final tick of the window: the controller leaves the count state here.
    assign expire_o = (cnt_q == LAST_V);
endmodule

// File: rtl/rds_seq_ctrl.sv
module rds_seq_ctrl
    import rds_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clr_n_sync_i,
    input  logic       wdog_edge_i,
    input  logic       wdog_en_i,
    input  logic       sleep_i,
    input  logic [1:0] osc_mode_i,
    input  logic       expire_i,
    output logic       load_o,
    output logic       use_long_o,
    output logic       hold_o,
    output logic       tmo_flag_o,
    output logic       wake_o
);
    seq_state_e state_q, state_d;
    seq_evt_t   evt;
    logic       por_pend_q;
    logic       flag_q;
    logic       wake_q;

    always_comb begin
        evt.clr_low   = !clr_n_sync_i;
        evt.wdog_take = wdog_edge_i && wdog_en_i && clr_n_sync_i;
        evt.asleep    = sleep_i;
    end

    // Load on leaving the clear wait, or on any accepted watchdog edge.
    assign load_o     = ((state_q == SEQ_WAIT_CLR) && !evt.clr_low) || evt.wdog_take;
    assign use_long_o = wants_long(por_pend_q, osc_mode_e'(osc_mode_i));

    always_comb begin
        state_d = state_q;
        if (evt.clr_low) begin
            state_d = SEQ_WAIT_CLR;
        end else if (load_o) begin
            state_d = SEQ_COUNT;
        end else if ((state_q == SEQ_COUNT) && expire_i) begin
            state_d = SEQ_RUN;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= SEQ_WAIT_CLR;
            por_pend_q <= 1'b1;
            flag_q     <= 1'b1;
            wake_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == SEQ_COUNT) && (state_d == SEQ_RUN)) begin
                por_pend_q <= 1'b0;
            end
            if (evt.clr_low) begin
                flag_q <= 1'b1;
            end else if (evt.wdog_take) begin
                flag_q <= 1'b0;
            end
            wake_q <= evt.wdog_take && evt.asleep;
        end
    end

    assign hold_o     = (state_q != SEQ_RUN);
    assign tmo_flag_o = flag_q;
    assign wake_o     = wake_q;
endmodule

// File: rtl/rst_delay_seq.sv
module rst_delay_seq
    import rds_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 4608,
    parameter int unsigned SHORT_TICKS = 77,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       tick_clk_i,
    input  logic       por_i,
    input  logic       ext_clear_n_i,
    input  logic       wdog_expire_i,
    input  logic [1:0] osc_mode_i,
    input  logic       wdog_en_i,
    input  logic       sleep_i,
    output logic       core_rst_o,
    output logic       tmo_flag_o,
    output logic       wake_pulse_o
);
    logic clr_n_sync;
    logic wdog_sync;
    logic wdog_last_q;
    logic wdog_edge;
    logic load;
    logic use_long;
    logic expire;
    logic hold;

    rds_sync #(.STAGES(SYNC_STAGES)) i_clr_sync (
        .clk_i (tick_clk_i),
        .rst_i (por_i),
        .d_i   (ext_clear_n_i),
        .q_o   (clr_n_sync)
    );

    rds_sync #(.STAGES(SYNC_STAGES)) i_wdog_sync (
        .clk_i (tick_clk_i),
        .rst_i (por_i),
        .d_i   (wdog_expire_i),
        .q_o   (wdog_sync)
    );

    always_ff @(posedge tick_clk_i) begin
        if (por_i) wdog_last_q <= 1'b0;
        else       wdog_last_q <= wdog_sync;
    end

    assign wdog_edge = wdog_sync && !wdog_last_q;

    rds_delay_counter #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) i_counter (
        .clk_i      (tick_clk_i),
        .rst_i      (por_i),
        .load_i     (load),
        .use_long_i (use_long),
        .expire_o   (expire)
    );

    rds_seq_ctrl i_ctrl (
        .clk_i        (tick_clk_i),
        .rst_i        (por_i),
        .clr_n_sync_i (clr_n_sync),
        .wdog_edge_i  (wdog_edge),
        .wdog_en_i    (wdog_en_i),
        .sleep_i      (sleep_i),
        .osc_mode_i   (osc_mode_i),
        .expire_i     (expire),
        .load_o       (load),
        .use_long_o   (use_long),
        .hold_o       (hold),
        .tmo_flag_o   (tmo_flag_o),
        .wake_o       (wake_pulse_o)
    );

    // Power-on asserts reset at once; release only through the registered hold.
    assign core_rst_o = por_i | hold;
endmodule

// File: rtl/rds_checker.sv
module rds_checker (
    input logic clk_i,
    input logic por_i,
    input logic wdog_en_i,
    input logic sleep_i,
    input logic clr_n_sync,
    input logic wdog_edge,
    input logic core_rst_o,
    input logic tmo_flag_o,
    input logic wake_pulse_o
);
    p_por_forces_rst_r1: assert property (@(posedge clk_i)
        por_i |-> core_rst_o);

    p_clear_holds_rst_r2: assert property (@(posedge clk_i) disable iff (por_i)
        !clr_n_sync |=> core_rst_o);

    p_release_needs_clear_r2: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(core_rst_o) |-> $past(clr_n_sync));

    p_wdog_asserts_rst_r5: assert property (@(posedge clk_i) disable iff (por_i)
        (wdog_edge && wdog_en_i && clr_n_sync) |=> core_rst_o);

    p_wdog_clears_flag_r6: assert property (@(posedge clk_i) disable iff (por_i)
        (wdog_edge && wdog_en_i && clr_n_sync) |=> !tmo_flag_o);

    p_clear_sets_flag_r6: assert property (@(posedge clk_i) disable iff (por_i)
        !clr_n_sync |=> tmo_flag_o);

    p_wdog_off_keeps_run_r7: assert property (@(posedge clk_i) disable iff (por_i)
        (!wdog_en_i && !core_rst_o && clr_n_sync) |=> !core_rst_o);

    p_wake_single_tick_r8: assert property (@(posedge clk_i) disable iff (por_i)
        wake_pulse_o |=> !wake_pulse_o);

    p_wake_needs_sleep_r8: assert property (@(posedge clk_i) disable iff (por_i)
        wake_pulse_o |-> ($past(sleep_i) && core_rst_o));
endmodule

bind rst_delay_seq rds_checker i_rds_checker (
    .clk_i        (tick_clk_i),
    .por_i        (por_i),
    .wdog_en_i    (wdog_en_i),
    .sleep_i      (sleep_i),
    .clr_n_sync   (clr_n_sync),
    .wdog_edge    (wdog_edge),
    .core_rst_o   (core_rst_o),
    .tmo_flag_o   (tmo_flag_o),
    .wake_pulse_o (wake_pulse_o)
);

// File: tb/test_rst_delay_seq.sv
module test_rst_delay_seq;
    localparam int LONG_T  = 12;
    localparam int SHORT_T = 5;

    typedef struct packed {
        logic [1:0] mode;
        logic       is_wdog;
        logic       sleep;
        logic       long_exp;
        logic       flag;
        logic       wake;
    } vec_t;

    // mode, watchdog event, sleep, long delay, expected flag, expected wake
    localparam vec_t VECS [8] = '{
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_clear_n = 1'b1;
    logic       wdog = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       wdog_en = 1'b1;
    logic       sleep = 1'b0;
    logic       core_rst, tmo_flag, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rst_delay_seq #(.LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T), .SYNC_STAGES(2)) i_rst_delay_seq (
        .tick_clk_i    (clk),
        .por_i         (por),
        .ext_clear_n_i (ext_clear_n),
        .wdog_expire_i (wdog),
        .osc_mode_i    (mode),
        .wdog_en_i     (wdog_en),
        .sleep_i       (sleep),
        .core_rst_o    (core_rst),
        .tmo_flag_o    (tmo_flag),
        .wake_pulse_o  (wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge right after the event input was driven.
    task automatic measure(input bit pulse, output int n, output int wake3, output int wake_cnt);
        n = 0; wake3 = 0; wake_cnt = 0;
        while (n < 400) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (pulse && n == 1) wdog = 1'b0;
            if (wake) wake_cnt++;
            if (n == 3) wake3 = int'(wake);
            if (n >= 3 && !core_rst) break;
        end
    endtask

    task automatic clear_event();
        ext_clear_n = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        ext_clear_n = 1'b1;
    endtask

    task automatic do_por();
        por = 1'b1;
        #1;
        chk("R1 rst asserted with por before edge", int'(core_rst), 1);
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk("R1 flag after por", int'(tmo_flag), 1);
        chk("R1 wake after por", int'(wake), 0);
        por = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, w3, wc;
        @(negedge clk);
        do_por();
        measure(1'b0, n, w3, wc);
        chk("R3 power-on delay in RC mode is long", n, LONG_T + 3);

        for (int i = 0; i < 8; i++) begin
            mode  = VECS[i].mode;
            sleep = VECS[i].sleep;
            if (VECS[i].is_wdog) begin
                wdog = 1'b1;
                measure(1'b1, n, w3, wc);
            end else begin
                clear_event();
                measure(1'b0, n, w3, wc);
            end
            if (VECS[i].mode[1]) chk("R3 RC later reset delay", n, (VECS[i].long_exp ? LONG_T : SHORT_T) + 3);
            else                 chk("R4 crystal reset delay", n, LONG_T + 3);
            chk("R6 flag after event", int'(tmo_flag), int'(VECS[i].flag));
            if (VECS[i].is_wdog) begin
                chk("R8 wake after third edge", w3, int'(VECS[i].wake));
                chk("R8 wake lasts one tick", wc, int'(VECS[i].wake));
            end
            sleep = 1'b0;
        end

        // R7: watchdog disabled, pulse ignored
        wdog_en = 1'b0; sleep = 1'b1; mode = 2'b10;
        wdog = 1'b1;
        begin
            int rst_hi, wk;
            rst_hi = 0; wk = 0;
            for (int k = 0; k < 10; k++) begin
                @(posedge clk); @(negedge clk);
                if (k == 0) wdog = 1'b0;
                if (core_rst) rst_hi++;
                if (wake) wk++;
            end
            chk("R7 disabled watchdog no reset", rst_hi, 0);
            chk("R7 disabled watchdog no wake", wk, 0);
            chk("R7 disabled watchdog flag kept", int'(tmo_flag), 0);
        end
        wdog_en = 1'b1; sleep = 1'b0;

        // R9 and R5: second watchdog pulse during a long count reloads it
        mode = 2'b01;
        wdog = 1'b1;
        @(posedge clk); @(negedge clk);
        wdog = 1'b0;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        chk("R5 watchdog asserts reset", int'(core_rst), 1);
        wdog = 1'b1;
        measure(1'b1, n, w3, wc);
        chk("R9 reload on watchdog during count", n, LONG_T + 3);

        // R2: long clear low holds reset, then exact release
        mode = 2'b11;
        ext_clear_n = 1'b0;
        repeat (20) begin @(posedge clk); @(negedge clk); end
        chk("R2 reset held while clear low", int'(core_rst), 1);
        ext_clear_n = 1'b1;
        measure(1'b0, n, w3, wc);
        chk("R2 release after clear high", n, SHORT_T + 3);

        // R3/R9: clear interrupting the power-on delay keeps the long delay
        mode = 2'b10;
        do_por();
        repeat (6) begin @(posedge clk); @(negedge clk); end
        clear_event();
        measure(1'b0, n, w3, wc);
        chk("R3 power-on delay kept across clear", n, LONG_T + 3);
        clear_event();
        measure(1'b0, n, w3, wc);
        chk("R3 short delay after power-on completes", n, SHORT_T + 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule